// File: doc/BRIEF.md
# SPI Daisy-Chain Frame Shifter

This block is the receive and transmit front end of a serial control port on a chip that acts as a bus slave. The host drives a select line, a serial clock and a serial data line. The host's clock idles low, and the slave samples data on the rising edge. All three pins are brought into the system clock through synchronizers and sampled there. The block holds a 24-bit shift register that is a plain pass-through FIFO. Every bit that enters at the bottom pushes the oldest bit out of the top toward the serial output. This lets several devices share one select line in a chain, because each stage passes along whatever it held. It also lets a host read back, during the next transaction, exactly what it wrote in the last one.

The register does not track word boundaries. When select is released, the block looks at how many rising serial-clock edges arrived. If there were 24 or more, it publishes the latest 24 bits as a frame: a command byte in the top eight bits and a 16-bit payload below it. It marks the frame with a one-cycle valid strobe. If there were fewer, it raises a one-cycle abort strobe instead and leaves the published frame untouched. A controller behind the block can overwrite the payload half of the register between transactions, so that read-back data leaves on the next frame behind the echoed command byte.

Top module: `spi_frame_shifter`

## Requirements
- R1: After reset, `ser_out_oe`, `frame_valid` and `frame_abort` are 0, and `frame_cmd` and `frame_data` are all zeros. The shift register is also cleared, so the first transaction reads back 24 zero bits.
- R2: `ser_out_oe` is 0 whenever `sel_n` has been high for at least four system clocks. It is 1 once `sel_n` has been low for at least four system clocks.
- R3: While `sel_n` is low, each rising edge of `ser_clk` shifts the level of `ser_in` into bit 0 of the register, with earlier bits moving toward bit 23. Bits therefore enter most significant first.
- R4: When `sel_n` falls, `ser_out` takes bit 23 of the register. It then takes the new bit 23 on every falling `ser_clk` edge, and does not change before the first rising edge. The first 24 bits a host samples on its rising edges are therefore the register contents left by the previous transaction, most significant first.
- R5: In a transaction with more than 24 clock edges, output bit number k (counting from 0), for k of 24 or more, equals the input bit sent at position k-24.
- R6: When `sel_n` rises after 24 or more rising clock edges, `frame_valid` pulses for exactly one cycle. This happens SYNC_STAGES+1 system clocks after the raw rise is first sampled. In the same cycle, `frame_cmd` shows register bits [23:16] and `frame_data` shows bits [15:0], both holding the last 24 bits received.
- R7: When `sel_n` rises after fewer than 24 rising edges (zero included), `frame_abort` pulses for one cycle, there is no `frame_valid`, and `frame_cmd` and `frame_data` keep their old values. The bits that were shifted in still stay in the register.
- R8: A one-cycle `rd_load` while the port is idle replaces register bits [15:0] with `rd_word` and keeps bits [23:16]. The loaded word appears on `ser_out` in the next transaction.
- R9: `rd_load` has no effect while the port is selected.
- R10: Each release of `sel_n` produces exactly one of `frame_valid` and `frame_abort`, never both at once.
- R11: `ser_clk` edges while `sel_n` is high do not shift the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Serial select from host, active low, asynchronous |
| ser_clk | input | 1 | Serial clock from host, idles low, asynchronous |
| ser_in | input | 1 | Serial data from host, sampled on rising `ser_clk` |
| ser_out | output | 1 | Serial data to host or next chain stage |
| ser_out_oe | output | 1 | Output enable for the `ser_out` pad driver; 0 means high impedance |
| rd_load | input | 1 | One-cycle request to load read-back data into the payload bits |
| rd_word | input | DATA_W (16) | Read-back word for `rd_load` |
| frame_cmd | output | CMD_W (8) | Command byte of the last valid frame |
| frame_data | output | DATA_W (16) | Payload of the last valid frame |
| frame_valid | output | 1 | One-cycle strobe: a frame of 24 or more bits ended |
| frame_abort | output | 1 | One-cycle strobe: a frame ended short and was discarded |

## Verification
The assertions assume that every high phase of `sel_n` lasts well over SYNC_STAGES+2 system clocks. They also assume that each serial clock phase lasts at least four system clocks, and that `ser_in` settles a few system clocks before the rising edge that samples it. The same conditions let the decode-latency property pin the strobe to a single cycle offset. The bench drives the serial pins from a task with six system clocks per half period. It changes data two clocks before each rising edge and keeps ten idle clocks between transactions. Random frame lengths, data and read-back loads all stay within these limits.

// File: rtl/spi_fs_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial frame shifter.
// Assumes: nothing beyond the IEEE 1800-2017 package rules.
package spi_fs_pkg;

    // Synchronised view of the three serial pins.
    typedef struct packed {
        logic sel_n;
        logic sclk;
        logic din;
    } pins_t;

    // Reset value of the pins: deselected, clock low, data low.
    localparam pins_t PINS_IDLE = '{sel_n: 1'b1, sclk: 1'b0, din: 1'b0};

    // Single-cycle events derived from the synchronised pins.
    typedef struct packed {
        logic active;     // select is asserted (synchronised)
        logic sel_fall;   // select just asserted
        logic sel_rise;   // select just released
        logic clk_rise;   // rising serial clock while selected
        logic clk_fall;   // falling serial clock while selected
        logic din;        // synchronised data bit
    } events_t;

    // Outcome of a transaction at select release.
    typedef enum logic [1:0] {
        OUTCOME_NONE  = 2'd0,
        OUTCOME_FRAME = 2'd1,
        OUTCOME_SHORT = 2'd2
    } outcome_e;

endpackage

// File: rtl/spi_fs_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a small vector of asynchronous pins.
// Assumes: each bit is sampled independently; bits that must be coherent
// are held stable for several system clocks around their use.
module spi_fs_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/spi_fs_edges.sv
`timescale 1ns/1ps
// Edge detector for the synchronised select and serial clock.
// Assumes: inputs are already synchronous to clk; clock edges are only
// reported while select is asserted.
module spi_fs_edges
    import spi_fs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pins_t   pins,
    output events_t ev
);

    logic sel_prev_q;
    logic sclk_prev_q;

    // Remember the previous level of select and clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_prev_q  <= PINS_IDLE.sel_n;
            sclk_prev_q <= PINS_IDLE.sclk;
        end else begin
            sel_prev_q  <= pins.sel_n;
            sclk_prev_q <= pins.sclk;
        end
    end

    // Compare current and previous levels to form the events.
    always_comb begin
        ev.active   = !pins.sel_n;
        ev.sel_fall = !pins.sel_n &&  sel_prev_q;
        ev.sel_rise =  pins.sel_n && !sel_prev_q;
        ev.clk_rise = !pins.sel_n &&  pins.sclk && !sclk_prev_q;
        ev.clk_fall = !pins.sel_n && !pins.sclk &&  sclk_prev_q;
        ev.din      =  pins.din;
    end

endmodule

// File: rtl/spi_fs_bitcnt.sv
`timescale 1ns/1ps
// Saturating count of rising serial clock edges in one transaction.
// Classifies the transaction when select is released.
// Assumes: select assertion and the first clock edge are separated by
// at least one system clock.
module spi_fs_bitcnt
    import spi_fs_pkg::*;
#(
    parameter int LIMIT = 24
) (
    input  logic     clk,
    input  logic     rst_n,
    input  events_t  ev,
    output outcome_e outcome
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Clear at select assertion, count rising edges up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ev.sel_fall) begin
            cnt_q <= '0;
        end else if (ev.clk_rise && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Classify the finished transaction on the release cycle.
    always_comb begin
        if (!ev.sel_rise) begin
            outcome = OUTCOME_NONE;
        end else if (cnt_q == CNT_MAX) begin
            outcome = OUTCOME_FRAME;
        end else begin
            outcome = OUTCOME_SHORT;
        end
    end

endmodule

// File: rtl/spi_fs_shreg.sv
`timescale 1ns/1ps
// Pass-through shift register with serial output and parallel payload load.
// Assumes: the load request is synchronous to clk; it is honoured only while
// the port is deselected so that a frame in flight is never corrupted.
module spi_fs_shreg
    import spi_fs_pkg::*;
#(
    parameter int FRAME_W = 24,
    parameter int LOAD_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  events_t            ev,
    input  logic               load_req,
    input  logic [LOAD_W-1:0]  load_val,
    output logic [FRAME_W-1:0] frame,
    output logic               out_bit,
    output logic               out_en
);

    localparam int TOP = FRAME_W - 1;

    logic [FRAME_W-1:0] sreg_q;
    logic               out_bit_q;
    logic               out_en_q;

    // Shift in on rising clock; load the payload bits only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (ev.clk_rise) begin
            sreg_q <= {sreg_q[TOP-1:0], ev.din};
        end else if (load_req && !ev.active) begin
            sreg_q[LOAD_W-1:0] <= load_val;
        end
    end

    // Present the top bit at select assertion and after each falling clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bit_q <= 1'b0;
        end else if (ev.sel_fall || ev.clk_fall) begin
            out_bit_q <= sreg_q[TOP];
        end
    end

    // Enable the output driver only while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en_q <= 1'b0;
        end else begin
            out_en_q <= ev.active;
        end
    end

    assign frame   = sreg_q;
    assign out_bit = out_bit_q;
    assign out_en  = out_en_q;

endmodule

// File: rtl/spi_frame_shifter.sv
`timescale 1ns/1ps
// Serial slave front end: synchronises the serial pins, shifts data through a
// command+payload register, drives the serial output for chaining and
// read-back, and publishes complete frames at select release.
// Assumes: clk runs at least four times the serial clock; the serial clock
// idles low; sel_n stays high for several system clocks between frames.
module spi_frame_shifter
    import spi_fs_pkg::*;
#(
    parameter int CMD_W       = 8,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              ser_clk,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              ser_out_oe,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rd_word,
    output logic [CMD_W-1:0]  frame_cmd,
    output logic [DATA_W-1:0] frame_data,
    output logic              frame_valid,
    output logic              frame_abort
);

    localparam int FRAME_W = CMD_W + DATA_W;

    pins_t              pins_s;
    events_t            ev;
    outcome_e           outcome;
    logic [FRAME_W-1:0] frame_w;

    logic [CMD_W-1:0]   cmd_q;
    logic [DATA_W-1:0]  data_q;
    logic               valid_q;
    logic               abort_q;

    spi_fs_sync #(
        .WIDTH   ($bits(pins_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sel_n, ser_clk, ser_in}),
        .d_out (pins_s)
    );

    spi_fs_edges u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pins_s),
        .ev    (ev)
    );

    spi_fs_bitcnt #(
        .LIMIT (FRAME_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .outcome (outcome)
    );

    spi_fs_shreg #(
        .FRAME_W (FRAME_W),
        .LOAD_W  (DATA_W)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .load_req (rd_load),
        .load_val (rd_word),
        .frame    (frame_w),
        .out_bit  (ser_out),
        .out_en   (ser_out_oe)
    );

    // Capture a complete frame and raise the matching one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            valid_q <= (outcome == OUTCOME_FRAME);
            abort_q <= (outcome == OUTCOME_SHORT);
            if (outcome == OUTCOME_FRAME) begin
                cmd_q  <= frame_w[FRAME_W-1:DATA_W];
                data_q <= frame_w[DATA_W-1:0];
            end
        end
    end

    assign frame_cmd   = cmd_q;
    assign frame_data  = data_q;
    assign frame_valid = valid_q;
    assign frame_abort = abort_q;

endmodule

// File: rtl/spi_fs_checker.sv
`timescale 1ns/1ps
// Protocol checker for the frame shifter, bound to the top module.
// Assumes: sel_n high phases last longer than SYNC_STAGES+2 system clocks.
module spi_fs_checker #(
    parameter int CMD_W       = 8,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              ser_out_oe,
    input logic [CMD_W-1:0]  frame_cmd,
    input logic [DATA_W-1:0] frame_data,
    input logic              frame_valid,
    input logic              frame_abort
);

    localparam logic [3:0] HI_SAT  = 4'd15;
    localparam logic [3:0] LATENCY = 4'(SYNC_STAGES + 1);

    logic [3:0] hi_cnt;

    // Count consecutive cycles with the raw select high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!sel_n) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HI_SAT) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && frame_abort));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    assert_abort_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |=> !frame_abort);

    assert_frame_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(frame_cmd) && $stable(frame_data)));

    assert_decode_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid || frame_abort) |-> (hi_cnt == LATENCY));

    assert_oe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt >= 4'd4) |-> !ser_out_oe);

endmodule

bind spi_frame_shifter spi_fs_checker #(
    .CMD_W       (CMD_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_n       (sel_n),
    .ser_out_oe  (ser_out_oe),
    .frame_cmd   (frame_cmd),
    .frame_data  (frame_data),
    .frame_valid (frame_valid),
    .frame_abort (frame_abort)
);

// File: tb/spi_frame_shifter_tb.sv
`timescale 1ns/1ps
module spi_frame_shifter_tb;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_in = 1'b0;
    logic        rd_load = 1'b0;
    logic [15:0] rd_word = '0;
    logic        ser_out, ser_out_oe, frame_valid, frame_abort;
    logic [7:0]  frame_cmd;
    logic [15:0] frame_data;

    int total = 0;
    int bad   = 0;
    int nv = 0;
    int na = 0;
    logic [23:0] mdl = '0;

    always #2.5 clk = ~clk;

    spi_frame_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
        .ser_in(ser_in), .ser_out(ser_out), .ser_out_oe(ser_out_oe),
        .rd_load(rd_load), .rd_word(rd_word), .frame_cmd(frame_cmd),
        .frame_data(frame_data), .frame_valid(frame_valid),
        .frame_abort(frame_abort)
    );

    // Count strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) nv++;
            if (frame_abort) na++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Expected output stream: old register MSB first, then the new bits.
    function automatic logic [63:0] exp_out(logic [23:0] old, logic [63:0] b, int n);
        logic [63:0] e = '0;
        for (int k = 0; k < n; k++) begin
            if (k < 24) e[n-1-k] = old[23-k];
            else        e[n-1-k] = b[n-1-(k-24)];
        end
        return e;
    endfunction

    function automatic logic [23:0] shift_model(logic [23:0] old, logic [63:0] b, int n);
        logic [23:0] r = old;
        for (int i = n - 1; i >= 0; i--) r = {r[22:0], b[i]};
        return r;
    endfunction

    // One transaction of n bits, MSB first; optional load during bit load_at.
    task automatic xfer(input int n, input logic [63:0] b, input int load_at,
                        output logic [63:0] got);
        got = '0;
        @(negedge clk) sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
        chk(ser_out_oe == 1'b1, "R2 oe active", 64'(ser_out_oe), 64'd1);
        for (int k = 0; k < n; k++) begin
            got[n-1-k] = ser_out;
            ser_in = b[n-1-k];
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            if (k == load_at) begin
                @(negedge clk) begin rd_load = 1'b1; rd_word = 16'($urandom); end
                @(negedge clk) rd_load = 1'b0;
                repeat (HALF - 2) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
            ser_clk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        sel_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(ser_out_oe == 1'b0, "R2 oe idle", 64'(ser_out_oe), 64'd0);
    endtask

    task automatic run(input int n, input logic [63:0] b, input int load_at);
        logic [23:0] old = mdl;
        int v0 = nv;
        int a0 = na;
        logic [23:0] prev = {frame_cmd, frame_data};
        logic [63:0] got;
        logic [63:0] e;
        xfer(n, b, load_at, got);
        e = exp_out(old, b, n);
        if (load_at >= 0)
            chk(got == e, "R9 load ignored", got, e); // R9 indirectly via next run too
        else if (n > 24)
            chk(got == e, "R5 pass-through", got, e);
        else
            chk(got == e, "R4 read-back R3 shift", got, e);
        mdl = shift_model(old, b, n);
        if (n >= 24) begin
            chk(nv == v0 + 1 && na == a0, "R6/R10 valid count",
                64'(nv - v0), 64'd1);
            chk({frame_cmd, frame_data} == mdl, "R6 frame content",
                64'({frame_cmd, frame_data}), 64'(mdl));
        end else begin
            chk(na == a0 + 1 && nv == v0, "R7/R10 abort count",
                64'(na - a0), 64'd1);
            chk({frame_cmd, frame_data} == prev, "R7 frame held",
                64'({frame_cmd, frame_data}), 64'(prev));
        end
    endtask

    task automatic idle_load(input logic [15:0] d);
        @(negedge clk) begin rd_load = 1'b1; rd_word = d; end
        @(negedge clk) rd_load = 1'b0;
        mdl[15:0] = d; // R8: payload replaced, command byte kept
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (5) @(negedge clk);
        chk(ser_out_oe == 0 && frame_valid == 0 && frame_abort == 0,
            "R1 reset strobes", 64'({ser_out_oe, frame_valid, frame_abort}), 64'd0);
        chk({frame_cmd, frame_data} == 0, "R1 reset frame",
            64'({frame_cmd, frame_data}), 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        run(24, 64'hA51234, -1);               // R1 read-back of zeros, R3
        run(24, 64'h3C_F00D, -1);              // R4 previous frame echoed
        run(10, 64'h2AB, -1);                  // R7 short frame
        run(0, 64'h0, -1);                     // R7 no clock at all
        run(30, 64'h2F_1234_5678, -1);         // R5 and R6 last 24 bits
        idle_load(16'hBEEF);                   // R8
        run(24, 64'h00_0000, -1);              // R8 seen on output
        run(24, 64'h11_2233, 5);               // R9 mid-frame load
        run(24, 64'h44_5566, -1);              // R9 confirmed by read-back
        repeat (3) begin                       // R11 clocks while idle
            @(negedge clk) begin ser_clk = 1'b1; ser_in = ~ser_in; end
            repeat (HALF) @(negedge clk);
            ser_clk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        run(24, 64'h77_8899, -1);              // R11 register untouched

        for (int t = 0; t < 40; t++) begin
            int n;
            logic [63:0] b;
            b = {$urandom, $urandom};
            n = ($urandom_range(3, 0) == 0) ? int'($urandom_range(23, 1))
                                            : int'($urandom_range(40, 24));
            if ($urandom_range(2, 0) == 0) idle_load(16'($urandom));
            run(n, b, ($urandom_range(5, 0) == 0) ? 3 : -1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule